// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block turns the system clock into scanline and frame timing for one of two video standards. A clock divider produces one line strobe per line period. The line period is the clock frequency divided by the product of frame rate and lines per frame, and it is fixed at elaboration for each standard. A line counter advances on each line strobe. It raises a blanking level at the standard's first blanking line. When the last line of the frame has finished, it returns to line zero, drops blanking and issues a frame-start strobe.

A single select input chooses between the 60 Hz standard (263 lines, blanking from line 240) and the 50 Hz standard (313 lines, blanking from line 256). The select is taken in only when a frame wraps, so a frame is never cut short or stretched by a change in the middle. A second divider counts line strobes without regard to frames and emits an audio-update strobe every 32 lines. The surrounding logic uses the strobes as clock enables.

Top module: `vid_line_seq`

## Requirements
- R1: `line_stb` is high for one cycle every PER clocks, where PER = floor(CLK_HZ / (rate × lines)) of the standard in effect. The first pulse is visible after the PER-th rising edge following reset release.
- R2: `line_num` rises by exactly one in the cycle after each `line_stb` pulse, and it holds its value in every other cycle.
- R3: A `line_stb` while `line_num` is at the last line (262 in the 60 Hz standard, 311+1 = 312 in the 50 Hz standard) makes `line_num` 0. `frame_stb` is high in that same cycle.
- R4: `vblank` goes high in the cycle in which `line_num` becomes the blanking line (240 for 60 Hz, 256 for 50 Hz). It stays high until the cycle in which `line_num` returns to 0.
- R5: `audio_stb` pulses once for every 32 `line_stb` pulses, in the cycle in which `line_num` advances. Its count runs freely across frame boundaries.
- R6: `std_sel` (0 = 60 Hz, 1 = 50 Hz) is taken in only at a frame wrap, and it sets the period, the last line and the blanking line of the next frame. A change at any other time has no effect on the current frame. The first frame after reset uses the 60 Hz standard.
- R7: While `rst_n` is low, every output is 0 and all counters are cleared.
- R8: `line_stb`, `frame_stb` and `audio_stb` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| std_sel | input | 1 | Standard select: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 313 lines |
| line_stb | output | 1 | One-cycle pulse at the end of each line period |
| line_num | output | LW (9) | Current line number within the frame |
| vblank | output | 1 | High during vertical blanking |
| frame_stb | output | 1 | One-cycle pulse when a new frame begins |
| audio_stb | output | 1 | One-cycle pulse every 32 lines |

## Verification
`line_stb` is due one register after the clock divider reaches its last count. `line_num`, `vblank`, `frame_stb` and `audio_stb` follow one further edge later, in the cycle after that strobe. The bench advances a cycle-level expected model once per rising edge, using the select value present at that edge. It compares every output on the falling edge that follows, so each result is examined exactly in the cycle it is due. Frame lengths are also checked at every observed wrap, against the standard that was latched for that frame, and this covers mid-frame select changes.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } vstd_e;

  // Clocks per scanline for a given clock, frame rate and frame height.
  function automatic int unsigned clocks_per_line(
    input longint unsigned clk_hz,
    input int unsigned     rate,
    input int unsigned     lines
  );
    return int'(clk_hz / (longint'(rate) * longint'(lines)));
  endfunction

endpackage

// File: rtl/vls_line_timer.sv
module vls_line_timer #(
  parameter int unsigned PER_A = 16,
  parameter int unsigned PER_B = 16,
  localparam int unsigned PER_MAX = (PER_A > PER_B) ? PER_A : PER_B,
  localparam int unsigned CW = (PER_MAX > 2) ? $clog2(PER_MAX) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_q,
  output logic line_stb
);

  localparam logic [CW-1:0] LAST_A = CW'(PER_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(PER_B - 1);

  logic [CW-1:0] cnt_q, cnt_d, last_sel;
  logic          stb_d;

  generate
    if (PER_A == PER_B) begin : g_same_period
      assign last_sel = LAST_A;
    end else begin : g_two_periods
      assign last_sel = std_q ? LAST_B : LAST_A;
    end
  endgenerate

  always_comb begin
    stb_d = (cnt_q >= last_sel);
    cnt_d = stb_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      line_stb <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      line_stb <= stb_d;
    end
  end

  // R1: a line pulse is only ever issued together with a restarted divider
  a_r1_stb_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |-> (cnt_q == '0));
  // R1: the divider never runs past the period in effect
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_sel);
  // R8: single-cycle line pulse
  a_r8_line_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> !line_stb);

endmodule

// File: rtl/vls_frame_ctr.sv
module vls_frame_ctr #(
  parameter int unsigned LINES_A = 263,
  parameter int unsigned BLANK_A = 240,
  parameter int unsigned LINES_B = 313,
  parameter int unsigned BLANK_B = 256,
  localparam int unsigned LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int unsigned LW = $clog2(LMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          std_sel,
  output logic [LW-1:0] line_num,
  output logic          vblank,
  output logic          frame_stb,
  output logic          std_q
);

  localparam logic [LW-1:0] LAST_A = LW'(LINES_A - 1);
  localparam logic [LW-1:0] LAST_B = LW'(LINES_B - 1);
  localparam logic [LW-1:0] VB_A   = LW'(BLANK_A);
  localparam logic [LW-1:0] VB_B   = LW'(BLANK_B);

  logic [LW-1:0] line_d, last_sel, blank_sel, line_inc;
  logic          vb_d, fs_d, std_d, line_en;

  assign last_sel  = std_q ? LAST_B : LAST_A;
  assign blank_sel = std_q ? VB_B : VB_A;
  assign line_inc  = line_num + 1'b1;
  assign line_en   = line_stb;

  always_comb begin
    line_d = line_num;
    vb_d   = vblank;
    std_d  = std_q;
    fs_d   = 1'b0;
    if (line_en) begin
      if (line_num == last_sel) begin
        line_d = '0;
        vb_d   = 1'b0;
        fs_d   = 1'b1;
        std_d  = std_sel;
      end else begin
        line_d = line_inc;
        if (line_inc == blank_sel) vb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_num  <= '0;
      vblank    <= 1'b0;
      frame_stb <= 1'b0;
      std_q     <= 1'b0;
    end else begin
      frame_stb <= fs_d;
      if (line_en) begin
        line_num <= line_d;
        vblank   <= vb_d;
        std_q    <= std_d;
      end
    end
  end

  // R2: without a line pulse the line number does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(line_num));
  // R3: a frame start always shows line zero outside blanking
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (line_num == '0 && !vblank));
  // R4: blanking only starts on the standard's blanking line
  a_r4_vb_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> (line_num == blank_sel));
  // R6: the standard changes only with a frame start
  a_r6_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> $stable(std_q));
  // R8: single-cycle frame pulse
  a_r8_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

endmodule

// File: rtl/vls_tick_div.sv
module vls_tick_div #(
  parameter int unsigned DIV = 32,
  localparam int unsigned AW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam logic [AW-1:0] LAST = AW'(DIV - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = en && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= tick_d;
      if (en) cnt_q <= cnt_d;
    end
  end

  // R5: the audio tick follows a line pulse
  a_r5_tick_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en));
  // R5: after a tick the count has restarted
  a_r5_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt_q == '0));
  // R8: single-cycle audio pulse
  a_r8_audio_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/vid_line_seq.sv
module vid_line_seq #(
  parameter longint unsigned CLK_HZ = 33868800,
  parameter int unsigned RATE_A      = 60,
  parameter int unsigned LINES_A     = 263,
  parameter int unsigned BLANK_A     = 240,
  parameter int unsigned RATE_B      = 50,
  parameter int unsigned LINES_B     = 313,
  parameter int unsigned BLANK_B     = 256,
  parameter int unsigned AUDIO_LINES = 32,
  localparam int unsigned LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int unsigned LW   = $clog2(LMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  output logic          line_stb,
  output logic [LW-1:0] line_num,
  output logic          vblank,
  output logic          frame_stb,
  output logic          audio_stb
);

  import vls_pkg::*;

  localparam int unsigned PER_A = clocks_per_line(CLK_HZ, RATE_A, LINES_A);
  localparam int unsigned PER_B = clocks_per_line(CLK_HZ, RATE_B, LINES_B);

  logic std_q;

  vls_line_timer #(
    .PER_A (PER_A),
    .PER_B (PER_B)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .std_q    (std_q),
    .line_stb (line_stb)
  );

  vls_frame_ctr #(
    .LINES_A (LINES_A),
    .BLANK_A (BLANK_A),
    .LINES_B (LINES_B),
    .BLANK_B (BLANK_B)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb),
    .std_sel   (std_sel),
    .line_num  (line_num),
    .vblank    (vblank),
    .frame_stb (frame_stb),
    .std_q     (std_q)
  );

  vls_tick_div #(
    .DIV (AUDIO_LINES)
  ) u_audio (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (line_stb),
    .tick  (audio_stb)
  );

  // R5: an audio tick coincides with a line advance
  a_r5_audio_with_advance: assert property (@(posedge clk) disable iff (!rst_n)
    audio_stb |-> $past(line_stb));
  // R4: blanking never spans a frame start
  a_r4_vb_clear_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> !vblank);

endmodule

// File: tb/vid_line_seq_tb.sv
`timescale 1ns/1ps
module vid_line_seq_tb_top;

  localparam longint unsigned CLK_HZ = 188000;
  localparam int unsigned LW = 9;
  localparam int unsigned WD_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          std_sel;
  logic          line_stb, vblank, frame_stb, audio_stb;
  logic [LW-1:0] line_num;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vid_line_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_sel   (std_sel),
    .line_stb  (line_stb),
    .line_num  (line_num),
    .vblank    (vblank),
    .frame_stb (frame_stb),
    .audio_stb (audio_stb)
  );

  // expected values from the requirements
  function automatic int f_per(input bit s);
    return s ? int'(CLK_HZ / (50 * 313)) : int'(CLK_HZ / (60 * 263));
  endfunction
  function automatic int f_last(input bit s);
    return s ? 312 : 262;
  endfunction
  function automatic int f_blank(input bit s);
    return s ? 256 : 240;
  endfunction

  int m_cnt, m_line, m_acnt, m_wrap_last;
  bit m_ls, m_vb, m_fs, m_aud, m_std;
  int prev_line;
  bit prev_ls, prev_fs, prev_aud;

  task automatic model_clear();
    m_cnt = 0; m_line = 0; m_acnt = 0; m_wrap_last = 0;
    m_ls = 0; m_vb = 0; m_fs = 0; m_aud = 0; m_std = 0;
  endtask

  task automatic model_step(input bit sel);
    bit ls_old;
    ls_old = m_ls;
    if (m_cnt == f_per(m_std) - 1) begin m_cnt = 0; m_ls = 1; end
    else begin m_cnt++; m_ls = 0; end
    m_fs = 0; m_aud = 0;
    if (ls_old) begin
      if (m_line == f_last(m_std)) begin
        m_wrap_last = f_last(m_std);
        m_line = 0; m_fs = 1; m_vb = 0; m_std = sel;
      end else begin
        m_line++;
        if (m_line == f_blank(m_std)) m_vb = 1;
      end
      if (m_acnt == 31) begin m_acnt = 0; m_aud = 1; end
      else m_acnt++;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 line_stb", line_stb, m_ls);
    chk("R2 line_num", line_num, m_line);
    chk("R4 vblank", vblank, m_vb);
    chk("R3 frame_stb", frame_stb, m_fs);
    chk("R5 audio_stb", audio_stb, m_aud);
    if (frame_stb) begin
      chk("R3 wrap to zero", line_num, 0);
      chk("R6 frame last line", prev_line, m_wrap_last);
    end
    if (line_stb)  chk("R8 line_stb width", prev_ls, 0);
    if (frame_stb) chk("R8 frame_stb width", prev_fs, 0);
    if (audio_stb) chk("R8 audio_stb width", prev_aud, 0);
    prev_line = line_num; prev_ls = line_stb;
    prev_fs = frame_stb;  prev_aud = audio_stb;
  endtask

  task automatic check_reset_state();
    chk("R7 line_stb", line_stb, 0);
    chk("R7 line_num", line_num, 0);
    chk("R7 vblank", vblank, 0);
    chk("R7 frame_stb", frame_stb, 0);
    chk("R7 audio_stb", audio_stb, 0);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step(std_sel);
    else model_clear();
    @(negedge clk);
    compare();
  endtask

  // mode 0: random toggles, 1: hold 50 Hz, 2: hold 60 Hz
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      if (mode == 0 && ($urandom % 400) == 0) std_sel = ~std_sel;
      else if (mode == 1) std_sel = 1'b1;
      else if (mode == 2) std_sel = 1'b0;
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    std_sel = 1'b1;
    model_clear();
    prev_line = 0; prev_ls = 0; prev_fs = 0; prev_aud = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    // R6: 50 Hz select is held from reset, yet the first frame is 60 Hz
    run(3000, 1);
    // R6: 50 Hz frames
    run(7000, 1);
    // random select changes, mostly mid-frame
    run(9000, 0);
    // R7: asynchronous reset in the middle of a frame
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    model_clear();
    prev_line = 0; prev_ls = 0; prev_fs = 0; prev_aud = 0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    run(6500, 2);
    run(9000, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule